// File: doc/BRIEF.md
# Phase-Angle Triac Trigger Timer

This block fires a gate trigger pulse for a triac a programmable time after an edge on a sync input, which is normally driven by a mains zero-cross detector. Changing the delay moves the firing angle within each half cycle and so sets the power delivered to an AC load. All timing runs on a fixed internal time base that a prescaler derives from the system clock. One tick lasts `TICK_DIV` clocks, and the default is chosen for a 25.6 µs tick from a 50 MHz clock.

A host writes a single configuration word. The word holds the delay in ticks, which edge of the sync input counts, and the gate polarity. The edge choice and the polarity take effect at once. The delay is held in a staging register and only moves into use on the next qualifying sync edge, so a firing cycle already in progress is never disturbed. A status output shows that a staged delay has not yet been adopted. The sync input is asynchronous to the tick, so the output edge carries up to one tick of jitter.

Top module: `triac_phase_timer`

## Requirements
- R1: After reset `gateOut` is low, `updatePending` is low, the delay is 0 and the edge mode is rising. No pulse appears until a qualifying sync edge is seen.
- R2: The time base ticks once every `TICK_DIV` clocks. Delay and pulse width are whole multiples of that period.
- R3: `wrMode` selects the qualifying edge: 2'b01 rising only, 2'b10 falling only, 2'b11 both, 2'b00 none. An edge that does not qualify produces no pulse and leaves `updatePending` unchanged.
- R4: For an active delay D (0 included), the gate asserts no earlier than (D+1)*TICK_DIV+3 clock edges and no later than (D+2)*TICK_DIV+2 clock edges after the sync input changes. The edge count starts from the first edge after the change.
- R5: Each pulse stays asserted for exactly `PULSE_TICKS`*TICK_DIV clocks. The gate then stays deasserted until it fires again after another qualifying edge.
- R6: With `wrInvert` set the gate idles high and pulses low. With it clear the gate idles low and pulses high. The change takes effect the clock after the write.
- R7: A write sets `updatePending` on the next clock. A firing cycle already counting keeps the old delay. The first pulse that uses the new delay is the one after the next qualifying edge.
- R8: `updatePending` clears at the tick that adopts the staged delay on a qualifying edge, and at no other time.
- R9: A qualifying edge that arrives while a delay is still counting restarts the count from the active delay. The interrupted cycle produces no pulse.
- R10: When several writes arrive before a qualifying edge, only the last delay written is adopted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| syncIn | input | 1 | Zero-cross sync, asynchronous |
| wrEn | input | 1 | Configuration write strobe, one clock |
| wrDelay | input | DELAY_W | Delay in ticks to stage |
| wrMode | input | 2 | Qualifying edge select |
| wrInvert | input | 1 | Gate polarity invert |
| gateOut | output | 1 | Triac gate drive |
| updatePending | output | 1 | Staged delay not yet adopted |

## Verification
If the delay counter or the staging register holds a wrong value, the fault shows up as a gate edge outside the one-tick latency window on the very next firing cycle. If the edge detector is wrong, a pulse appears for an edge that does not qualify, or goes missing for one that does, within one delay period. If the adoption logic is wrong, `updatePending` is stuck or clears early. The bench observes this at the port right after each write and after each firing. A wrong pulse-width counter changes the asserted length and is measured to the exact clock.

// File: rtl/triac_pkg.sv
package triac_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_COUNT = 2'd1,
    PH_PULSE = 2'd2
  } phase_t;

  typedef struct packed {
    logic loadCount;
    logic decCount;
    logic loadWidth;
    logic decWidth;
    logic adopt;
    logic gateSet;
    logic gateClr;
  } ctrlStrobe_t;

endpackage

// File: rtl/triac_tick_gen.sv
module triac_tick_gen #(
  parameter int TICK_DIV = 1280
) (
  input  logic clk,
  input  logic rstN,
  output logic tick
);
  localparam int PRE_W = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [PRE_W-1:0] LAST = PRE_W'(TICK_DIV - 1);

  logic [PRE_W-1:0] preCnt;

  generate
    if (TICK_DIV == 1) begin : g_every
      assign tick = 1'b1;
      always_ff @(posedge clk) preCnt <= '0;
    end else begin : g_div
      assign tick = (preCnt == LAST);
      always_ff @(posedge clk) begin
        if (!rstN)      preCnt <= '0;
        else if (tick)  preCnt <= '0;
        else            preCnt <= preCnt + 1'b1;
      end
      assert_tick_period_R2: assert property (@(posedge clk) disable iff (!rstN)
        tick |=> !tick);
    end
  endgenerate

endmodule

// File: rtl/triac_datapath.sv
module triac_datapath
  import triac_pkg::*;
#(
  parameter int DELAY_W     = 16,
  parameter int PULSE_TICKS = 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               tick,
  input  logic               syncIn,
  input  logic               wrEn,
  input  logic [DELAY_W-1:0] wrDelay,
  input  logic [1:0]         wrMode,
  input  logic               wrInvert,
  input  ctrlStrobe_t        strobe,
  output logic               qualEdge,
  output logic               countZero,
  output logic               widthLast,
  output logic               gateOut,
  output logic               updatePending
);
  localparam int WID_W = (PULSE_TICKS > 1) ? $clog2(PULSE_TICKS) : 1;
  localparam logic [WID_W-1:0] WID_LOAD = WID_W'(PULSE_TICKS - 1);

  logic               syncMeta, syncSafe, syncPrev;
  logic [DELAY_W-1:0] stagedDelay, activeDelay, countVal;
  logic [WID_W-1:0]   widthCnt;
  logic [1:0]         modeReg;
  logic               invertReg, pendingFlag, gateActive;
  logic               riseSeen, fallSeen;

  // Two-flop synchronizer, then sampling at tick boundaries
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncMeta <= 1'b0;
      syncSafe <= 1'b0;
      syncPrev <= 1'b0;
    end else begin
      syncMeta <= syncIn;
      syncSafe <= syncMeta;
      if (tick) syncPrev <= syncSafe;
    end
  end

  assign riseSeen = tick && syncSafe && !syncPrev;
  assign fallSeen = tick && !syncSafe && syncPrev;
  assign qualEdge = (riseSeen && modeReg[0]) || (fallSeen && modeReg[1]);

  // Configuration: mode and polarity immediate, delay staged
  always_ff @(posedge clk) begin
    if (!rstN) begin
      stagedDelay <= '0;
      activeDelay <= '0;
      modeReg     <= 2'b01;
      invertReg   <= 1'b0;
      pendingFlag <= 1'b0;
    end else begin
      if (strobe.adopt && pendingFlag) activeDelay <= stagedDelay;
      if (wrEn) begin
        stagedDelay <= wrDelay;
        modeReg     <= wrMode;
        invertReg   <= wrInvert;
        pendingFlag <= 1'b1;
      end else if (strobe.adopt) begin
        pendingFlag <= 1'b0;
      end
    end
  end

  // Delay and width counters
  always_ff @(posedge clk) begin
    if (!rstN) begin
      countVal <= '0;
      widthCnt <= '0;
    end else begin
      if (strobe.loadCount)     countVal <= pendingFlag ? stagedDelay : activeDelay;
      else if (strobe.decCount) countVal <= countVal - 1'b1;
      if (strobe.loadWidth)     widthCnt <= WID_LOAD;
      else if (strobe.decWidth) widthCnt <= widthCnt - 1'b1;
    end
  end

  assign countZero = (countVal == '0);
  assign widthLast = (widthCnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN)               gateActive <= 1'b0;
    else if (strobe.gateClr) gateActive <= 1'b0;
    else if (strobe.gateSet) gateActive <= 1'b1;
  end

  assign gateOut       = gateActive ^ invertReg;
  assign updatePending = pendingFlag;

  assert_count_no_underflow_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.decCount |-> countVal != '0);
  assert_width_no_underflow_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.decWidth |-> widthCnt != '0);
  assert_gate_on_tick_R2: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(gateActive) |-> $past(tick));
  assert_fire_at_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(gateActive) |-> $past(countVal == '0));
  assert_pending_set_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pendingFlag) |-> $past(wrEn));
  assert_pending_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pendingFlag) |-> $past(strobe.adopt && qualEdge));

endmodule

// File: rtl/triac_control.sv
module triac_control
  import triac_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        tick,
  input  logic        qualEdge,
  input  logic        countZero,
  input  logic        widthLast,
  output ctrlStrobe_t strobe
);
  phase_t phase, phaseNext;

  always_comb begin
    phaseNext = phase;
    strobe    = '0;
    if (qualEdge) begin
      // new qualifying edge always restarts the cycle
      phaseNext        = PH_COUNT;
      strobe.loadCount = 1'b1;
      strobe.adopt     = 1'b1;
      strobe.gateClr   = 1'b1;
    end else if (tick) begin
      unique case (phase)
        PH_COUNT: begin
          if (countZero) begin
            phaseNext        = PH_PULSE;
            strobe.gateSet   = 1'b1;
            strobe.loadWidth = 1'b1;
          end else begin
            strobe.decCount = 1'b1;
          end
        end
        PH_PULSE: begin
          if (widthLast) begin
            phaseNext      = PH_IDLE;
            strobe.gateClr = 1'b1;
          end else begin
            strobe.decWidth = 1'b1;
          end
        end
        default: phaseNext = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) phase <= PH_IDLE;
    else       phase <= phaseNext;
  end

  assert_pulse_from_count_R4: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_PULSE && $past(phase) != PH_PULSE) |-> $past(phase == PH_COUNT && countZero));
  assert_restart_no_fire_R9: assert property (@(posedge clk) disable iff (!rstN)
    qualEdge |=> phase == PH_COUNT);
  assert_single_strobe_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.gateSet, strobe.gateClr}));

endmodule

// File: rtl/triac_phase_timer.sv
module triac_phase_timer
  import triac_pkg::*;
#(
  parameter int TICK_DIV    = 1280,
  parameter int DELAY_W     = 16,
  parameter int PULSE_TICKS = 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               syncIn,
  input  logic               wrEn,
  input  logic [DELAY_W-1:0] wrDelay,
  input  logic [1:0]         wrMode,
  input  logic               wrInvert,
  output logic               gateOut,
  output logic               updatePending
);
  logic        tick, qualEdge, countZero, widthLast;
  ctrlStrobe_t strobe;

  triac_tick_gen #(.TICK_DIV(TICK_DIV)) uTick (
    .clk(clk), .rstN(rstN), .tick(tick)
  );

  triac_datapath #(.DELAY_W(DELAY_W), .PULSE_TICKS(PULSE_TICKS)) uData (
    .clk(clk), .rstN(rstN), .tick(tick), .syncIn(syncIn),
    .wrEn(wrEn), .wrDelay(wrDelay), .wrMode(wrMode), .wrInvert(wrInvert),
    .strobe(strobe), .qualEdge(qualEdge), .countZero(countZero),
    .widthLast(widthLast), .gateOut(gateOut), .updatePending(updatePending)
  );

  triac_control uCtrl (
    .clk(clk), .rstN(rstN), .tick(tick), .qualEdge(qualEdge),
    .countZero(countZero), .widthLast(widthLast), .strobe(strobe)
  );

endmodule

// File: tb/sim_triac_phase_timer.sv
module sim_triac_phase_timer;
  localparam int DIV = 4;
  localparam int PT  = 2;
  localparam int DW  = 16;

  logic clk = 1'b0, rstN = 1'b0, syncIn = 1'b0, wrEn = 1'b0, wrInvert = 1'b0;
  logic [DW-1:0] wrDelay = '0;
  logic [1:0] wrMode = 2'b01;
  logic gateOut, updatePending;
  int errors = 0, checks = 0;
  logic invCur = 1'b0;

  always #10 clk = ~clk;

  triac_phase_timer #(.TICK_DIV(DIV), .DELAY_W(DW), .PULSE_TICKS(PT)) u0 (
    .clk(clk), .rstN(rstN), .syncIn(syncIn), .wrEn(wrEn), .wrDelay(wrDelay),
    .wrMode(wrMode), .wrInvert(wrInvert), .gateOut(gateOut), .updatePending(updatePending)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic writeCfg(input int d, input logic [1:0] m, input logic inv);
    @(negedge clk);
    wrEn = 1'b1; wrDelay = DW'(d); wrMode = m; wrInvert = inv;
    @(negedge clk);
    wrEn = 1'b0;
    invCur = inv;
    check(updatePending == 1'b1, "R7 pending after write", updatePending, 1);
    check(gateOut == inv, "R6 idle level after write", gateOut, inv);
  endtask

  task automatic toggleSync();
    @(negedge clk);
    syncIn = ~syncIn;
  endtask

  // measure from the most recent sync change; called right after toggleSync
  task automatic expectPulse(input int d, input string req);
    int n = 0;
    int w = 0;
    bit found = 0;
    int lo = (d + 1) * DIV + 3;
    int hi = (d + 2) * DIV + 2;
    while (!found && n < hi + 2 * DIV) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (gateOut == ~invCur) found = 1;
    end
    check(found && n >= lo && n <= hi, {req, " R4 latency"}, n, lo);
    if (found) begin
      w = 1;
      while (gateOut == ~invCur && w < PT * DIV + 4) begin
        @(posedge clk); @(negedge clk);
        if (gateOut == ~invCur) w++;
      end
      check(w == PT * DIV, {req, " R5 R2 width"}, w, PT * DIV);
    end
  endtask

  task automatic expectNone(input int cyc, input string req);
    bit seen = 0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (gateOut != invCur) seen = 1;
    end
    check(!seen, req, seen, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(gateOut == 1'b0, "R1 gate after reset", gateOut, 0);
    check(updatePending == 1'b0, "R1 pending after reset", updatePending, 0);
    expectNone(60, "R1 no pulse before sync edge");
    // reset state: delay 0, rising mode
    toggleSync(); expectPulse(0, "R1 reset delay");
    toggleSync(); expectNone(6 * DIV, "R1 R3 reset mode falling ignored");

    // rising sweep
    for (int d = 0; d < 7; d++) begin
      writeCfg(d, 2'b01, 1'b0);
      toggleSync(); expectPulse(d, "R3 rising");
      check(updatePending == 1'b0, "R8 cleared at edge", updatePending, 0);
      toggleSync(); expectNone((d + 4) * DIV, "R3 falling ignored");
    end
    // falling sweep
    for (int d = 0; d < 7; d++) begin
      writeCfg(d, 2'b10, 1'b0);
      toggleSync(); expectNone((d + 4) * DIV, "R3 rising ignored");
      check(updatePending == 1'b1, "R3 R8 pending kept", updatePending, 1);
      toggleSync(); expectPulse(d, "R3 falling");
      check(updatePending == 1'b0, "R8 cleared at edge", updatePending, 0);
    end
    // both edges
    for (int d = 0; d < 5; d++) begin
      writeCfg(d, 2'b11, 1'b0);
      toggleSync(); expectPulse(d, "R3 both first");
      toggleSync(); expectPulse(d, "R3 both second");
    end
    // none
    writeCfg(1, 2'b00, 1'b0);
    toggleSync(); expectNone(6 * DIV, "R3 mode none rise");
    toggleSync(); expectNone(6 * DIV, "R3 mode none fall");
    check(updatePending == 1'b1, "R8 pending held in mode none", updatePending, 1);

    // inverted polarity
    for (int d = 0; d < 4; d++) begin
      writeCfg(d, 2'b01, 1'b1);
      toggleSync(); expectPulse(d, "R6 inverted");
      check(gateOut == 1'b1, "R6 inverted idle", gateOut, 1);
      toggleSync(); expectNone(4 * DIV, "R6 inverted falling ignored");
    end
    writeCfg(3, 2'b01, 1'b0);
    check(gateOut == 1'b0, "R6 normal idle", gateOut, 0);
    toggleSync(); expectPulse(3, "R6 normal");
    toggleSync(); expectNone(4 * DIV, "R6 falling ignored");

    // staged update mid-cycle
    writeCfg(10, 2'b01, 1'b0);
    toggleSync();
    fork
      expectPulse(10, "R7 old delay kept");
      begin repeat (12) @(negedge clk); writeCfg(2, 2'b01, 1'b0); end
    join
    check(updatePending == 1'b1, "R7 pending after old pulse", updatePending, 1);
    toggleSync(); expectNone(6 * DIV, "R7 falling ignored");
    toggleSync(); expectPulse(2, "R7 new delay");
    check(updatePending == 1'b0, "R8 cleared after adopt", updatePending, 0);
    toggleSync(); expectNone(4 * DIV, "R7 falling ignored");

    // restart during counting
    for (int gap = 3; gap < 12; gap += 4) begin
      writeCfg(8, 2'b11, 1'b0);
      toggleSync();
      repeat (gap * DIV / 2 + 1) @(negedge clk);
      toggleSync(); expectPulse(8, "R9 restart");
      expectNone(12 * DIV, "R9 no extra pulse");
    end

    // last write wins
    writeCfg(7, 2'b01, 1'b0);
    writeCfg(1, 2'b01, 1'b0);
    if (syncIn) begin toggleSync(); expectNone(4 * DIV, "R10 setup"); end
    toggleSync(); expectPulse(1, "R10 last write");
    check(updatePending == 1'b0, "R10 R8 pending cleared", updatePending, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule